// File: doc/BRIEF.md
# Graphics Port Transaction Status Sequencer

This block sits on the target side of a pipelined graphics port. The master queues read and write requests by pulling an active-low queue strobe low. Each request carries a direction, a priority and a block count. The sequencer stores the requests in a small queue. After each data phase it decides what the master should do next, and reports that decision on a 3-bit status bus qualified by a grant output.

High-priority requests always go before low-priority ones, and requests of the same priority go in arrival order. The master can hold off the return of low-priority read data with an active-low read-buffer-full input. That input is looked at only when a data phase is about to start. High-priority traffic and low-priority writes ignore it. When the queue is empty and the master asks for the bus, the sequencer grants ownership for one clock.

Top module: `gfx_status_seq`

## Requirements
- R1: While `rst` is high at a clock edge, the block empties the queue. After that edge `gnt` is 0, `status` is 3'b111, `q_full` is 0 and `overflow` is 0.
- R2: A request is queued at each rising edge where `pipe_n` is 0 and the queue is not full. No request is queued at an edge where `pipe_n` is 1. Each queued request produces exactly one data phase.
- R3: The queue holds 8 requests, and `q_full` is 1 while it holds 8. A request offered while the queue is full is discarded and never served. `overflow` is 1 for the single cycle after that edge.
- R4: `status` encodes the phase as follows: bit 1 = write, bit 0 = high priority. So 000 is low-priority read return, 001 is high-priority read return, 010 is low-priority write request and 011 is high-priority write request. 111 grants bus ownership. A high-priority request is served before any low-priority request.
- R5: Requests of the same priority are served in the order they were queued.
- R6: `req_len` holds the block count minus one (0 to 3 means 1 to 4 blocks). A data phase keeps `gnt` at 1 and `status` unchanged for exactly that many clocks. The next phase may start in the clock right after the last block.
- R7: A low-priority read is not started while `rbf_n` is 0 at the deciding edge, and neither are the low-priority requests behind it. High-priority requests and low-priority writes are started whatever the value of `rbf_n`.
- R8: `rbf_n` is sampled only at the edge that starts a data phase. Pulling it low during a low-priority read phase does not shorten that phase.
- R9: If both queues are empty at a deciding edge and `bus_req` is 1, `gnt` is 1 with `status` 111 for one clock. If nothing is pending and `bus_req` is 0, `gnt` is 0.
- R10: While `gnt` is 1, `status` never carries the reserved codes 100, 101 or 110.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| pipe_n | input | 1 | Queue strobe, active low; one request per edge while low |
| req_write | input | 1 | Request direction: 1 write, 0 read |
| req_hi | input | 1 | Request priority: 1 high, 0 low |
| req_len | input | 2 | Block count minus one |
| bus_req | input | 1 | Master asks for bus ownership |
| rbf_n | input | 1 | Master read buffer full, active low |
| gnt | output | 1 | Grant; qualifies `status` |
| status | output | 3 | Next-action code, meaningful only while `gnt` is 1 |
| q_full | output | 1 | Queue holds 8 requests |
| overflow | output | 1 | One-cycle pulse after a request was dropped |

## Verification
A request queued at edge e is visible to the decision at edge e+1 at the earliest, so its grant appears in the cycle after e+1. A one-cycle `bus_req` likewise gives a one-cycle 111 grant one edge later. `q_full` and `overflow` change in the cycle right after the pushing edge. The bench drives inputs and samples outputs on falling edges. The driver posts each expected phase (code and block count) into a queue before causing it. A monitor compares every granted cycle against the head entry and counts blocks down, so a phase that starts early, ends early, arrives out of order or appears unrequested is caught in the cycle it happens.

// File: rtl/gfx_status_seq.sv
module gfx_status_seq #(
  parameter int DEPTH = 8,
  parameter int LEN_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pipe_n,
  input  logic             req_write,
  input  logic             req_hi,
  input  logic [LEN_W-1:0] req_len,
  input  logic             bus_req,
  input  logic             rbf_n,
  output logic             gnt,
  output logic [2:0]       status,
  output logic             q_full,
  output logic             overflow
);

  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int EW = LEN_W + 1;

  logic [EW-1:0] hi_mem [DEPTH];
  logic [EW-1:0] lo_mem [DEPTH];
  logic [PW-1:0] hi_wr, hi_rd, lo_wr, lo_rd;
  logic [CW-1:0] hi_cnt, lo_cnt;
  logic [CW:0]   total;
  logic [LEN_W-1:0] rem;
  logic first;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  wire [EW-1:0] hi_head = hi_mem[hi_rd];
  wire [EW-1:0] lo_head = lo_mem[lo_rd];

  assign total  = {1'b0, hi_cnt} + {1'b0, lo_cnt};
  assign q_full = (total == (CW+1)'(DEPTH));

  wire pushing  = !pipe_n && !q_full;
  wire push_hi  = pushing && req_hi;
  wire push_lo  = pushing && !req_hi;
  wire hold     = gnt && (rem != '0);
  wire take_hi  = !hold && (hi_cnt != '0);
  wire take_lo  = !hold && (hi_cnt == '0) && (lo_cnt != '0) && (lo_head[LEN_W] || rbf_n);
  wire give_bus = !hold && (hi_cnt == '0) && (lo_cnt == '0) && bus_req;

  always_ff @(posedge clk) begin
    if (push_hi) hi_mem[hi_wr] <= {req_write, req_len};
    if (push_lo) lo_mem[lo_wr] <= {req_write, req_len};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_wr <= '0; hi_rd <= '0; lo_wr <= '0; lo_rd <= '0;
      hi_cnt <= '0; lo_cnt <= '0;
      gnt <= 1'b0; status <= 3'b111; rem <= '0; first <= 1'b0;
      overflow <= 1'b0;
    end else begin
      overflow <= !pipe_n && q_full;
      if (push_hi) hi_wr <= nxt(hi_wr);
      if (push_lo) lo_wr <= nxt(lo_wr);
      if (take_hi) hi_rd <= nxt(hi_rd);
      if (take_lo) lo_rd <= nxt(lo_rd);
      hi_cnt <= hi_cnt + CW'(push_hi) - CW'(take_hi);
      lo_cnt <= lo_cnt + CW'(push_lo) - CW'(take_lo);
      if (hold) begin
        rem   <= rem - 1'b1;
        first <= 1'b0;
      end else if (take_hi) begin
        gnt <= 1'b1; status <= {1'b0, hi_head[LEN_W], 1'b1};
        rem <= hi_head[LEN_W-1:0]; first <= 1'b1;
      end else if (take_lo) begin
        gnt <= 1'b1; status <= {1'b0, lo_head[LEN_W], 1'b0};
        rem <= lo_head[LEN_W-1:0]; first <= 1'b1;
      end else if (give_bus) begin
        gnt <= 1'b1; status <= 3'b111; rem <= '0; first <= 1'b1;
      end else begin
        gnt <= 1'b0; status <= 3'b111; rem <= '0; first <= 1'b0;
      end
    end
  end

  assert_no_reserved_R10: assert property (@(posedge clk) disable iff (rst)
    gnt |-> (status[2] == 1'b0 || status == 3'b111));

  assert_count_bound_R3: assert property (@(posedge clk) disable iff (rst)
    total <= (CW+1)'(DEPTH));

  assert_full_holds_R3: assert property (@(posedge clk) disable iff (rst)
    (q_full && !take_hi && !take_lo) |=> q_full);

  assert_lo_read_gate_R7: assert property (@(posedge clk) disable iff (rst)
    (gnt && first && status == 3'b000) |-> $past(rbf_n));

  assert_hi_first_R4: assert property (@(posedge clk) disable iff (rst)
    (gnt && first && status[2] == 1'b0 && status[0] == 1'b0) |-> $past(hi_cnt == '0));

  assert_phase_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (gnt && !first) |-> ($past(gnt) && $stable(status)));

  assert_bus_grant_empty_R9: assert property (@(posedge clk) disable iff (rst)
    (gnt && status == 3'b111) |-> $past(hi_cnt == '0 && lo_cnt == '0 && bus_req));

endmodule

// File: tb/gfx_status_seq_test.sv
module gfx_status_seq_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pipe_n = 1'b1, req_write = 1'b0, req_hi = 1'b0, bus_req = 1'b0, rbf_n = 1'b1;
  logic [1:0] req_len = 2'd0;
  logic gnt, q_full, overflow;
  logic [2:0] status;

  int checks = 0;
  int errors = 0;

  typedef struct { logic [2:0] code; int blocks; } phase_t;
  phase_t exp_q[$];
  phase_t cur;
  int rem = 0;

  gfx_status_seq uut (
    .clk(clk), .rst(rst), .pipe_n(pipe_n), .req_write(req_write), .req_hi(req_hi),
    .req_len(req_len), .bus_req(bus_req), .rbf_n(rbf_n),
    .gnt(gnt), .status(status), .q_full(q_full), .overflow(overflow)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic push(input bit w, input bit h, input int len);
    @(negedge clk);
    pipe_n = 1'b0; req_write = w; req_hi = h; req_len = 2'(len - 1);
    @(posedge clk);
    #1 pipe_n = 1'b1;
  endtask

  task automatic expect_phase(input logic [2:0] code, input int blocks);
    phase_t p;
    p.code = code; p.blocks = blocks;
    exp_q.push_back(p);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (gnt) begin
          chk(status[2] == 1'b0 || status == 3'b111, "R10", "reserved status", status, 7);
          if (rem == 0) begin
            if (exp_q.size() == 0) begin
              chk(1'b0, "R9", "unexpected grant status", status, -1);
              rem = 1;
              cur.code = status;
            end else begin
              cur = exp_q.pop_front();
              chk(status == cur.code, "R4", "phase order/code", status, cur.code);
              rem = cur.blocks;
            end
          end else begin
            chk(status == cur.code, "R6", "status changed in phase", status, cur.code);
          end
          rem--;
        end else if (rem > 0) begin
          chk(1'b0, "R6", "phase cut short, blocks left", rem, 0);
          rem = 0;
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    chk(1'b0, "R2", "watchdog expired", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(gnt == 1'b0, "R1", "gnt after reset", gnt, 0);
    chk(status == 3'b111, "R1", "status after reset", status, 7);
    chk(q_full == 1'b0, "R1", "q_full after reset", q_full, 0);
    chk(overflow == 1'b0, "R1", "overflow after reset", overflow, 0);
    rst = 1'b0;
    idle(3);
    chk(gnt == 1'b0, "R2", "grant with strobe idle", gnt, 0);

    // R4 R5 R6: long low write, then mixed arrivals during it
    expect_phase(3'b010, 4);
    expect_phase(3'b011, 1);
    expect_phase(3'b001, 2);
    expect_phase(3'b000, 2);
    expect_phase(3'b010, 3);
    push(1, 0, 4);
    push(0, 0, 2);
    push(1, 1, 1);
    push(1, 0, 3);
    push(0, 1, 2);
    idle(20);
    chk(exp_q.size() == 0, "R5", "phases left after mixed set", exp_q.size(), 0);

    // R7: low read blocked, high read passes
    rbf_n = 1'b0;
    push(0, 0, 1);
    idle(4);
    chk(gnt == 1'b0, "R7", "low read started while buffer full", gnt, 0);
    expect_phase(3'b001, 2);
    expect_phase(3'b000, 1);
    push(0, 1, 2);
    idle(6);
    rbf_n = 1'b1;
    idle(6);
    chk(exp_q.size() == 0, "R7", "phases left after gated read", exp_q.size(), 0);

    // R7: low write not gated
    rbf_n = 1'b0;
    expect_phase(3'b010, 2);
    push(1, 0, 2);
    idle(6);
    rbf_n = 1'b1;
    chk(exp_q.size() == 0, "R7", "low write blocked by buffer full", exp_q.size(), 0);

    // R8: buffer full raised mid-phase
    expect_phase(3'b000, 4);
    push(0, 0, 4);
    @(negedge clk);
    @(negedge clk);
    rbf_n = 1'b0;
    idle(8);
    rbf_n = 1'b1;
    chk(exp_q.size() == 0, "R8", "phases left after mid-phase full", exp_q.size(), 0);

    // R3: fill queue, overflow, drop
    rbf_n = 1'b0;
    for (int i = 0; i < 8; i++) begin
      expect_phase(3'b000, (i % 4) + 1);
      push(0, 0, (i % 4) + 1);
    end
    @(negedge clk);
    chk(q_full == 1'b1, "R3", "q_full at 8", q_full, 1);
    chk(overflow == 1'b0, "R3", "overflow before drop", overflow, 0);
    push(0, 0, 4);
    @(negedge clk);
    chk(overflow == 1'b1, "R3", "overflow pulse", overflow, 1);
    chk(q_full == 1'b1, "R3", "q_full after drop", q_full, 1);
    @(negedge clk);
    chk(overflow == 1'b0, "R3", "overflow one cycle", overflow, 0);
    rbf_n = 1'b1;
    idle(40);
    chk(exp_q.size() == 0, "R3", "phases left after drain", exp_q.size(), 0);
    chk(q_full == 1'b0, "R3", "q_full after drain", q_full, 0);

    // R9: bus ownership grant
    expect_phase(3'b111, 1);
    @(negedge clk);
    bus_req = 1'b1;
    @(negedge clk);
    bus_req = 1'b0;
    idle(2);
    chk(gnt == 1'b0, "R9", "gnt with nothing pending", gnt, 0);
    chk(exp_q.size() == 0, "R9", "bus grant missing", exp_q.size(), 0);

    idle(5);
    chk(exp_q.size() == 0, "R2", "phases outstanding at end", exp_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule